// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full signed product of `2*WIDTH` bits. The multiplier operand is scanned one bit per clock, least significant bit first. Each bit is looked at together with the bit just below it, and the pair decides one of three actions on the multiplicand: subtract it, add it, or leave it out. A run of consecutive ones therefore costs a single subtract where the run begins and a single add where it ends. It does not cost one add for each set bit.

A user pulses `start` while the block is idle, with both operands on the inputs. `busy` then stays high for exactly `WIDTH` cycles, one partial step each. After that `done` pulses for one cycle with the result on `product`. The result holds until the next accepted start. The partial sum is kept one bit wider than the operand, so the most negative multiplicand needs no special case.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen by a clock edge while `busy` is 0 is accepted. `done` is then 1 after exactly `WIDTH` further clock edges and stays 1 for only one cycle.
- R3: From the edge that accepts a start, `busy` is 1 for exactly `WIDTH` cycles. It is 0 in the cycle in which `done` is 1.
- R4: When `done` is 1, `product` equals the signed product of the accepted `mcand` and `mplier`, both taken as two's-complement, in `2*WIDTH`-bit two's-complement form.
- R5: The most negative value times itself gives +2^(2*WIDTH-2). The most negative value times -1 gives +2^(WIDTH-1). Neither wraps.
- R6: A `start` pulse while `busy` is 1 is ignored. The result and the timing stay those of the run already in progress, and the input operands may change freely during a run.
- R7: While idle and with no `start`, `product` holds its last value.
- R8: At each step the pair (current multiplier bit, bit to its right) chooses the action. The bit to the right of the LSB is taken as 0. (1,0) subtracts the multiplicand, (0,1) adds it, and (0,0) and (1,1) leave the partial sum unchanged.
- R9: After each step the combined partial sum and multiplier shift right by one bit arithmetically, so the sign bit is copied into the top position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when `product` is valid |
| product | output | 2*WIDTH | Signed product |

## Verification
The hardest case to reach is the extreme partial sum. A multiplier whose top bits begin a long run of ones forces a subtract of the most negative multiplicand. That pushes the partial sum to the edge of the extra guard bit. The stimulus drives that case directly by crossing the most negative value, -1, alternating bit patterns and long runs of ones against each other. Random operands are added on top of these. A second case that is hard to reach is a `start` arriving while a run is in progress. The bench re-pulses `start` with different operands in the middle of some runs and expects both the result and the `done` timing to be unaffected.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      right_bit,
    output booth_op_e op
);
    always_comb begin
        case ({cur_bit, right_bit})
            2'b10:   op = OP_SUB;   // a run of ones begins
            2'b01:   op = OP_ADD;   // a run of ones has just ended
            default: op = OP_KEEP;  // inside a run of ones or of zeros
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] mc,
    input  booth_op_e     op,
    output logic [AW-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD:  res = acc + mc;
            OP_SUB:  res = acc - mc;
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/booth_step_ctr.sv
module booth_step_ctr #(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic last
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == CW'(STEPS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = '0;
        else if (advance)
            cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    localparam int AW = WIDTH + 1;   // guard bit keeps the most negative multiplicand exact

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [AW-1:0]    acc;   // upper partial sum
        logic [WIDTH-1:0] mq;    // multiplier, shifted out as the product fills in
        logic             qm1;   // bit to the right of the scanned bit
        logic [AW-1:0]    mc;    // sign-extended multiplicand
    } mul_state_t;

    mul_state_t state_d, state_q;

    logic          accept;
    logic          step_last;
    booth_op_e     step_op;
    logic [AW-1:0] step_sum;

    // internal views for the bound checker
    logic [AW-1:0] acc_view;
    logic [AW-1:0] mc_view;
    logic [1:0]    pair_view;

    assign accept = start && !state_q.busy;

    booth_recoder u_recoder (
        .cur_bit   (state_q.mq[0]),
        .right_bit (state_q.qm1),
        .op        (step_op)
    );

    booth_addsub #(.AW(AW)) u_addsub (
        .acc (state_q.acc),
        .mc  (state_q.mc),
        .op  (step_op),
        .res (step_sum)
    );

    booth_step_ctr #(.STEPS(WIDTH)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (state_q.busy),
        .last    (step_last)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (state_q.busy) begin
            // arithmetic right shift of {sum, multiplier, right bit}
            {state_d.acc, state_d.mq, state_d.qm1} = {step_sum[AW-1], step_sum, state_q.mq};
            if (step_last) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end
        end else if (start) begin
            state_d.busy = 1'b1;
            state_d.acc  = '0;
            state_d.mq   = mplier;
            state_d.qm1  = 1'b0;
            state_d.mc   = {mcand[WIDTH-1], mcand};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy      = state_q.busy;
    assign done      = state_q.done;
    assign product   = {state_q.acc[WIDTH-1:0], state_q.mq};
    assign acc_view  = state_q.acc;
    assign mc_view   = state_q.mc;
    assign pair_view = {state_q.mq[0], state_q.qm1};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [2*WIDTH-1:0]   product,
    input logic [WIDTH:0]       acc,
    input logic [WIDTH:0]       mc,
    input logic [1:0]           pair
);
    localparam int AW = WIDTH + 1;
    localparam int RW = $clog2(WIDTH + 2);

    logic [RW-1:0] run_cnt;
    logic [AW-1:0] acc_plus, acc_minus;

    assign acc_plus  = acc + mc;
    assign acc_minus = acc - mc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + 1'b1;
    end

    // R2: done is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done arrives after exactly WIDTH steps
    a_r2_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == RW'(WIDTH)));

    // R3: never busy while done
    a_r3_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: multiplicand untouched during a run
    a_r6_mc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mc));

    // R7: idle without start keeps the product
    a_r7_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    // R8, R9: skip pairs only shift arithmetically
    a_r8_skip_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (pair == 2'b00 || pair == 2'b11)) |=>
            (acc == {$past(acc[AW-1]), $past(acc[AW-1:1])}));

    // R8, R9: pair (1,0) subtracts, then shifts arithmetically
    a_r8_sub_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pair == 2'b10) |=>
            (acc == {$past(acc_minus[AW-1]), $past(acc_minus[AW-1:1])}));

    // R8, R9: pair (0,1) adds, then shifts arithmetically
    a_r8_add_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pair == 2'b01) |=>
            (acc == {$past(acc_plus[AW-1]), $past(acc_plus[AW-1:1])}));
endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) u_booth_mul_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .acc     (acc_view),
    .mc      (mc_view),
    .pair    (pair_view)
);

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
    localparam int W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     mcand = '0;
    logic [W-1:0]     mplier = '0;
    logic             busy;
    logic             done;
    logic [2*W-1:0]   product;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string cur_tag  = "R4";
    bit    checking = 1'b0;

    // reference model state
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    int          m_cnt  = 0;
    int          m_a = 0, m_b = 0;
    logic [63:0] m_prod = '0;

    booth_mul #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
        .mplier(mplier), .busy(busy), .done(done), .product(product)
    );

    always #2 clk = ~clk;   // 4 ns period

    // behavioural model: start accepted when idle, WIDTH busy cycles, then a done pulse
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == W) begin
                    m_busy = 0;
                    m_done = 1;
                    m_prod = 64'(longint'(m_a) * longint'(m_b));
                end
            end else if (start) begin
                m_busy = 1;
                m_cnt  = 0;
                m_a    = int'($signed(mcand));
                m_b    = int'($signed(mplier));
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (checking) begin
            check("R3 busy", 64'(busy), 64'(m_busy));
            check("R2 done", 64'(done), 64'(m_done));
            if (m_done) check({cur_tag, " product"}, 64'(product), m_prod[2*W-1:0]);
            else if (!m_busy) check("R7 product hold", 64'(product), m_prod[2*W-1:0]);
        end
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic run(input int a, input int b, input string tag, input bit poke);
        @(negedge clk);
        cur_tag = tag;
        mcand   = W'(a);
        mplier  = W'(b);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        mcand   = ~W'(a);
        mplier  = W'(b) ^ 8'h5a;
        if (poke) begin
            // R6: pulse start mid-run with unrelated operands
            repeat (2) @(negedge clk);
            mcand  = 8'h33;
            mplier = 8'hc4;
            start  = 1'b1;
            @(negedge clk);
            start  = 1'b0;
        end
        while (!m_done) @(negedge clk);
        @(negedge clk);
    endtask

    int corner [12] = '{-128, -127, -1, 0, 1, 127, 85, -86, 15, 112, -2, 3};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 product", 64'(product), 64'd0);
        rst_n = 1'b1;
        checking = 1'b1;

        run(2, -3, "R4", 0);
        run(-128, -128, "R5", 0);
        run(-128, -1, "R5", 0);
        run(-1, -128, "R5", 0);
        run(127, 127, "R4", 0);
        run(5, 8'h3c, "R8", 0);         // single run of ones in the middle
        run(-7, -1, "R8", 0);           // run of ones reaching the sign bit
        run(-128, 85, "R9", 0);         // alternating pairs, negative partial sums
        run(9, -11, "R6", 1);
        run(-128, 112, "R6", 1);

        // R7: idle cycles after a result
        cur_tag = "R7";
        repeat (5) @(negedge clk);

        foreach (corner[i]) begin
            foreach (corner[j]) begin
                run(corner[i], corner[j], "R4", 0);
            end
        end

        for (int k = 0; k < 800; k++) begin
            run(int'($signed(W'($urandom))), int'($signed(W'($urandom))), "R4", (k % 7) == 0);
        end

        // back-to-back: start in the same cycle done is seen
        @(negedge clk);
        cur_tag = "R2";
        mcand = 8'd100; mplier = 8'd200; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        mcand = 8'hf0; mplier = 8'h0f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule